// File: doc/BRIEF.md
# Key-guarded watchdog timer with early-warning stage

The block is a watchdog peripheral for a system that must recover from a hung processor. Software programs a timeout length and enables the countdown. It must then keep writing a restart code before the timeout runs out. If it fails to do so, the block drives a system reset pulse. It can also mirror that pulse onto an external reset pin, at either polarity. Each register accepts a write only when the write carries its own magic value, so a stray store cannot reprogram or disarm the timer.

The countdown is clocked by the system clock and advances only on cycles where a slow tick enable (nominally 32 kHz) is high. The length is programmed in units of 512 ticks, so 64 units make one second. In dual mode with the interrupt enabled, the first expiry raises an interrupt. The counter then reloads and runs the same length a second time before it resets the system. A separate software-reset register resets the system at once. The register port is a plain single-cycle write strobe with a combinational read-back.

Top module: `guard_timer`

## Requirements
- R1: After reset, the control register reads 0, the length register reads 0x0000FFE0 (maximum count), irq_o and sys_rst_o are low, and ext_rst_o is high.
- R2: A write to offset 0x00 changes the control register only when wdata[31:24] is 0x22. Only bits 0 (run), 1 (pin polarity, 1 = active high), 2 (pin drive), 3 (interrupt enable), 4 (auto-start flag), 6 (dual mode) and 8 (reset-source select) are kept. They read back in bits [8:0], and all other bits read as zero.
- R3: A write to offset 0x04 changes the length only when wdata[4:0] is 0x08. The count is taken from wdata[15:5] and reads back in the same position, with all other bits zero.
- R4: In single mode, sys_rst_o rises 512×L ticks after the load. The load occurs in the cycle after the run bit is set. A length of 0 behaves as 1.
- R5: Writing 0x00001971 to offset 0x08 while running reloads the counter, restarts the current 512-tick unit and clears irq_o. Any other value, or any write while stopped, has no effect.
- R6: With the run, dual-mode and interrupt-enable bits all set, irq_o rises after L units and sys_rst_o rises L units later. Without both of the last two bits, no interrupt is raised and the reset comes after L units.
- R7: Once raised, irq_o stays high, even through the reset pulse, until a valid restart or until the run bit is cleared.
- R8: Writing 0x00001209 to offset 0x14 makes sys_rst_o high in the next cycle whether or not the timer runs. Any other value has no effect.
- R9: While the run bit is clear, nothing counts and neither irq_o nor sys_rst_o is produced by the timer. Setting the run bit again starts a fresh full-length count.
- R10: Each reset pulse lasts exactly 16 ticks. It holds while no tick arrives, and the countdown pauses for its duration.
- R11: With the pin-drive bit set, ext_rst_o follows sys_rst_o when the polarity bit is 1 and its inverse when it is 0. With the pin-drive bit clear, ext_rst_o sits at the inactive level, which is the inverse of the polarity bit.
- R12: The countdown advances only on cycles where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Slow-tick enable, one cycle high per 32 kHz tick |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | 32 | Write data, including key field |
| bus_rdata_o | output | 32 | Read-back of the addressed register |
| irq_o | output | 1 | Early-warning interrupt |
| sys_rst_o | output | 1 | System reset pulse, active high |
| ext_rst_o | output | 1 | External reset pin at programmed polarity |

## Verification
A wrong count or prescaler state does not show at the ports until a timeout expires. It then moves the rise of sys_rst_o by whole 512-cycle units, so expiry times are measured against tight windows. A wrong stage flag shows up as a missing interrupt, or as a reset at one length instead of two, at the first expiry. A fault in key decoding shows on the very next read-back. Pulse-length and pin-polarity faults are visible within the 16 ticks of a pulse.

// File: rtl/gt_pkg.sv
// Shared constants for the guard timer: offsets, key values, control bits.
package gt_pkg;
    localparam int OFF_MODE  = 'h00;
    localparam int OFF_LEN   = 'h04;
    localparam int OFF_KICK  = 'h08;
    localparam int OFF_SWRST = 'h14;

    localparam logic [7:0]  MODE_KEY   = 8'h22;
    localparam logic [4:0]  LEN_KEY    = 5'h08;
    localparam logic [31:0] KICK_CODE  = 32'h0000_1971;
    localparam logic [31:0] SWRST_CODE = 32'h0000_1209;

    localparam int MODE_W  = 9;
    localparam logic [MODE_W-1:0] MODE_MASK = 9'h15F;
    localparam int LEN_LSB = 5;

    localparam int B_RUN   = 0;
    localparam int B_POL   = 1;
    localparam int B_PIN   = 2;
    localparam int B_IRQEN = 3;
    localparam int B_DUAL  = 6;

    typedef enum logic {ST_WARN, ST_FINAL} stage_e;
endpackage

// File: rtl/gt_regs.sv
// Register file: key-checked writes, command strobes, combinational read-back.
// Assumes single-cycle writes; strobes are valid only in the write cycle.
module gt_regs
    import gt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              kick_o,
    output logic              swrst_o,
    output logic [31:0]       rdata_o
);
    localparam int PAD_W = 32 - LEN_LSB - LEN_W;

    logic hit_mode, hit_len;

    // Decode accepted writes and command codes.
    always_comb begin
        hit_mode = we_i && (addr_i == ADDR_W'(OFF_MODE)) && (wdata_i[31:24] == MODE_KEY);
        hit_len  = we_i && (addr_i == ADDR_W'(OFF_LEN))  && (wdata_i[LEN_LSB-1:0] == LEN_KEY);
        kick_o   = we_i && (addr_i == ADDR_W'(OFF_KICK))  && (wdata_i == KICK_CODE);
        swrst_o  = we_i && (addr_i == ADDR_W'(OFF_SWRST)) && (wdata_i == SWRST_CODE);
    end

    // Hold the control and length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= '0;
            len_o  <= '1;
        end else begin
            if (hit_mode) mode_o <= wdata_i[MODE_W-1:0] & MODE_MASK;
            if (hit_len)  len_o  <= wdata_i[LEN_LSB +: LEN_W];
        end
    end

    // Return the addressed register without its key field.
    always_comb begin
        if (addr_i == ADDR_W'(OFF_MODE))
            rdata_o = {{(32-MODE_W){1'b0}}, mode_o};
        else if (addr_i == ADDR_W'(OFF_LEN))
            rdata_o = {{PAD_W{1'b0}}, len_o, {LEN_LSB{1'b0}}};
        else
            rdata_o = '0;
    end
endmodule

// File: rtl/gt_prescale.sv
// Tick prescaler: emits one unit strobe every UNIT_TICKS counted ticks.
// Assumes clear_i restarts the unit; counting only while run_i is high.
module gt_prescale #(
    parameter int UNIT_TICKS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic clear_i,
    output logic unit_o
);
    localparam int PRE_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(UNIT_TICKS - 1);

    logic [PRE_W-1:0] pre_q;

    // Unit boundary on the last tick of a unit.
    assign unit_o = run_i && tick_i && (pre_q == LAST);

    // Advance the sub-unit tick count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            pre_q <= '0;
        else if (run_i && tick_i)
            pre_q <= (pre_q == LAST) ? '0 : pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/gt_countdown.sv
// Two-stage countdown: warning stage (interrupt) then final stage (bite).
// Assumes len_i is sampled on every load; length 0 expires after one unit.
module gt_countdown
    import gt_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             dual_i,
    input  logic             irqen_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             kick_i,
    input  logic             unit_i,
    input  logic             hold_i,
    output logic             run_o,
    output logic             clear_o,
    output logic             bite_o,
    output logic             irq_o
);
    logic [LEN_W-1:0] cnt_q;
    stage_e           stage_q;
    logic             en_q;
    logic             load, last_unit, warn_now;

    // Load, run and expiry decisions.
    always_comb begin
        load      = en_i && (!en_q || kick_i);
        run_o     = en_i && !hold_i && !load;
        clear_o   = load || !en_i;
        last_unit = unit_i && !load && (cnt_q <= LEN_W'(1));
        warn_now  = last_unit && (stage_q == ST_WARN) && dual_i && irqen_i;
        bite_o    = last_unit && !warn_now;
    end

    // Count units, switch stages and hold the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            stage_q <= ST_WARN;
            en_q    <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            en_q <= en_i;
            if (!en_i) begin
                stage_q <= ST_WARN;
                irq_o   <= 1'b0;
            end else if (load) begin
                cnt_q   <= len_i;
                stage_q <= ST_WARN;
                irq_o   <= 1'b0;
            end else if (warn_now) begin
                cnt_q   <= len_i;
                stage_q <= ST_FINAL;
                irq_o   <= 1'b1;
            end else if (bite_o) begin
                cnt_q   <= len_i;
                stage_q <= ST_WARN;
            end else if (unit_i) begin
                cnt_q <= cnt_q - LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/gt_reset_pulse.sv
// Reset pulse generator and external pin driver.
// Assumes fire_i may arrive at any time and restarts the full pulse.
module gt_reset_pulse #(
    parameter int PULSE_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic fire_i,
    input  logic pin_en_i,
    input  logic pol_i,
    output logic sys_rst_o,
    output logic ext_rst_o
);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    logic [PW-1:0] left_q;

    // Count the remaining pulse ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (fire_i)
            left_q <= PW'(PULSE_TICKS);
        else if (tick_i && (left_q != '0))
            left_q <= left_q - PW'(1);
    end

    // Drive the system reset and the pin at its programmed polarity.
    always_comb begin
        sys_rst_o = (left_q != '0);
        ext_rst_o = pin_en_i ? (sys_rst_o ~^ pol_i) : !pol_i;
    end
endmodule

// File: rtl/guard_timer.sv
// Top level of the key-guarded watchdog.
// Assumes tick_i is a one-cycle enable derived from the slow clock.
module guard_timer
    import gt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int LEN_W       = 11,
    parameter int UNIT_TICKS  = 512,
    parameter int PULSE_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o,
    output logic              sys_rst_o,
    output logic              ext_rst_o
);
    logic [MODE_W-1:0] mode_q;
    logic [LEN_W-1:0]  len_q;
    logic kick, swrst_hit, unit, run, clear, bite;

    gt_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .mode_o(mode_q), .len_o(len_q),
        .kick_o(kick), .swrst_o(swrst_hit), .rdata_o(bus_rdata_o)
    );

    gt_prescale #(.UNIT_TICKS(UNIT_TICKS)) pre_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
        .clear_i(clear), .unit_o(unit)
    );

    gt_countdown #(.LEN_W(LEN_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .en_i(mode_q[B_RUN]), .dual_i(mode_q[B_DUAL]),
        .irqen_i(mode_q[B_IRQEN]), .len_i(len_q), .kick_i(kick), .unit_i(unit),
        .hold_i(sys_rst_o), .run_o(run), .clear_o(clear), .bite_o(bite),
        .irq_o(irq_o)
    );

    gt_reset_pulse #(.PULSE_TICKS(PULSE_TICKS)) pulse_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .fire_i(swrst_hit || bite),
        .pin_en_i(mode_q[B_PIN]), .pol_i(mode_q[B_POL]),
        .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o)
    );
endmodule

// File: rtl/gt_checker.sv
// Property checker for the guard timer, attached by bind.
module gt_checker
    import gt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_wdata_i,
    input logic [MODE_W-1:0] mode_q,
    input logic [LEN_W-1:0]  len_q,
    input logic              irq_o,
    input logic              sys_rst_o
);
    logic sw_cmd;
    assign sw_cmd = bus_we_i && (bus_addr_i == ADDR_W'(OFF_SWRST)) && (bus_wdata_i == SWRST_CODE);

    a_r2_mode_key: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == ADDR_W'(OFF_MODE) && bus_wdata_i[31:24] != MODE_KEY) |=> $stable(mode_q));

    a_r3_len_key: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == ADDR_W'(OFF_LEN) && bus_wdata_i[4:0] != LEN_KEY) |=> $stable(len_q));

    a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(mode_q[B_RUN]) && $past(mode_q[B_DUAL]) && $past(mode_q[B_IRQEN])));

    a_r7_irq_drop_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[B_RUN] |=> !irq_o);

    a_r8_swrst_now: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cmd |=> sys_rst_o);

    a_r9_no_bite_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> ($past(sw_cmd) || $past(mode_q[B_RUN])));

    a_r10_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_o && !tick_i) |=> sys_rst_o);
endmodule

bind guard_timer gt_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .mode_q(mode_q),
    .len_q(len_q), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/guard_timer_tb_top.sv
module guard_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        bus_we_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o, sys_rst_o, ext_rst_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    guard_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o)
    );

    // {addr, wdata, expected control read-back, expected length read-back}
    localparam logic [127:0] VEC [0:7] = '{
        {32'h00, 32'h2200_0156, 32'h156, 32'h0000_FFE0},
        {32'h00, 32'h2100_0001, 32'h156, 32'h0000_FFE0},
        {32'h04, 32'h0000_0048, 32'h156, 32'h0000_0040},
        {32'h04, 32'h0000_0067, 32'h156, 32'h0000_0040},
        {32'h04, 32'h00FF_FFE8, 32'h156, 32'h0000_FFE0},
        {32'h00, 32'h2200_00A0, 32'h000, 32'h0000_FFE0},
        {32'h08, 32'h0000_1971, 32'h000, 32'h0000_FFE0},
        {32'h04, 32'h0000_00A8, 32'h000, 32'h0000_00A0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int v, input int lo, input int hi);
        total++;
        if (v < lo || v > hi) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, v, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a;
        #1 d = bus_rdata_o;
    endtask

    task automatic wait_rst(input int maxn, output int n);
        n = 0;
        while (!sys_rst_o && n <= maxn) begin @(negedge clk); n++; end
    endtask

    task automatic wait_irq(input int maxn, output int n);
        n = 0;
        while (!irq_o && n <= maxn) begin @(negedge clk); n++; end
    endtask

    task automatic width(output int w);
        w = 0;
        while (sys_rst_o && w < 200) begin @(negedge clk); w++; end
    endtask

    task automatic quiet(input int n, output logic seen);
        seen = 1'b0;
        repeat (n) begin @(negedge clk); if (sys_rst_o) seen = 1'b1; end
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic s, seen;
        int n, w;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, d); chk("R1 control after reset", d, 32'h0);
        rd(8'h04, d); chk("R1 length after reset", d, 32'h0000_FFE0);
        chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        chk("R1 sys_rst after reset", {31'b0, sys_rst_o}, 32'h0);
        chk("R1 ext_rst after reset", {31'b0, ext_rst_o}, 32'h1);

        // R2 / R3 / R5 register table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][103:96], VEC[i][95:64]);
            rd(8'h00, d); chk("R2 control read-back", d, VEC[i][63:32]);
            rd(8'h04, d); chk("R3 length read-back", d, VEC[i][31:0]);
        end
        chk("R9 no reset while stopped", {31'b0, sys_rst_o}, 32'h0);

        // R4 R10 R11 single mode, pin active high
        wr(8'h04, 32'h48);
        wr(8'h00, 32'h2200_0007);
        wait_rst(3000, n);
        chk_rng("R4 single-mode expiry", n, 1022, 1030);
        chk("R11 pin follows reset, high polarity", {31'b0, ext_rst_o}, 32'h1);
        chk("R6 no irq in single mode", {31'b0, irq_o}, 32'h0);
        width(w);
        chk("R10 pulse width", w, 16);
        wr(8'h00, 32'h2200_0006);

        // R4 length zero acts as one unit
        wr(8'h04, 32'h08);
        wr(8'h00, 32'h2200_0001);
        wait_rst(3000, n);
        chk_rng("R4 zero length expiry", n, 510, 518);
        width(w);
        wr(8'h00, 32'h2200_0000);

        // R6 R7 R11 dual mode, pin disabled, low polarity
        wr(8'h04, 32'h48);
        wr(8'h00, 32'h2200_0049);
        wait_irq(3000, n);
        chk_rng("R6 warning stage expiry", n, 1022, 1030);
        chk("R6 no reset at warning", {31'b0, sys_rst_o}, 32'h0);
        wait_rst(3000, n);
        chk_rng("R6 final stage expiry", n, 1020, 1028);
        chk("R7 irq held through reset", {31'b0, irq_o}, 32'h1);
        chk("R11 pin idle when not driven", {31'b0, ext_rst_o}, 32'h1);
        width(w);
        wr(8'h00, 32'h2200_0048);
        @(negedge clk);
        chk("R7 irq cleared by stop", {31'b0, irq_o}, 32'h0);

        // R6 dual without interrupt enable
        wr(8'h00, 32'h2200_0041);
        wait_rst(3000, n);
        chk_rng("R6 dual without irq enable", n, 1022, 1030);
        chk("R6 no irq without enable", {31'b0, irq_o}, 32'h0);
        width(w);
        wr(8'h00, 32'h2200_0000);

        // R5 restarts keep the system alive; wrong code ignored
        wr(8'h00, 32'h2200_0001);
        seen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            quiet(700, s); seen |= s;
            wr(8'h08, 32'h0000_1971);
        end
        chk("R5 restarts prevent reset", {31'b0, seen}, 32'h0);
        quiet(500, s);
        wr(8'h08, 32'h0000_1970);
        wait_rst(3000, n);
        chk_rng("R5 wrong restart code ignored", n, 518, 528);
        width(w);
        wr(8'h00, 32'h2200_0000);

        // R5 R7 restart clears interrupt and starts a fresh warning stage
        wr(8'h00, 32'h2200_0049);
        wait_irq(3000, n);
        wr(8'h08, 32'h0000_1971);
        chk("R7 irq cleared by restart", {31'b0, irq_o}, 32'h0);
        wait_irq(3000, n);
        chk_rng("R5 restart reloads warning stage", n, 1020, 1028);
        wr(8'h00, 32'h2200_0000);

        // R9 stop halts; restart of run bit loads fresh
        wr(8'h00, 32'h2200_0009);
        quiet(800, s);
        wr(8'h00, 32'h2200_0008);
        quiet(3000, s);
        chk("R9 no reset while stopped", {31'b0, s}, 32'h0);
        chk("R9 no irq while stopped", {31'b0, irq_o}, 32'h0);
        wr(8'h00, 32'h2200_0009);
        wait_rst(3000, n);
        chk_rng("R9 fresh load on run", n, 1020, 1030);
        width(w);
        wr(8'h00, 32'h2200_0000);

        // R8 R10 R11 software reset while stopped, pin active low
        wr(8'h00, 32'h2200_0004);
        wr(8'h14, 32'h0000_1208);
        quiet(30, s);
        chk("R8 wrong code no reset", {31'b0, s}, 32'h0);
        wr(8'h14, 32'h0000_1209);
        chk("R8 software reset immediate", {31'b0, sys_rst_o}, 32'h1);
        chk("R11 pin low for low polarity", {31'b0, ext_rst_o}, 32'h0);
        width(w);
        chk("R10 software pulse width", w, 16);
        chk("R11 pin back to idle", {31'b0, ext_rst_o}, 32'h1);

        // R12 R10 counting needs ticks; pulse holds without ticks
        @(negedge clk); tick_i = 1'b0;
        wr(8'h00, 32'h2200_0001);
        quiet(3000, s);
        chk("R12 no expiry without ticks", {31'b0, s}, 32'h0);
        wr(8'h14, 32'h0000_1209);
        repeat (40) @(negedge clk);
        chk("R10 pulse holds without ticks", {31'b0, sys_rst_o}, 32'h1);
        tick_i = 1'b1;
        width(w);
        chk("R10 pulse width after ticks resume", w, 16);
        wait_rst(3000, n);
        chk_rng("R12 count runs once ticks resume", n, 1018, 1030);
        width(w);
        wr(8'h00, 32'h2200_0000);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule